// File: doc/BRIEF.md
# External Interrupt Pin Conditioner

This block turns an active-low external interrupt pin into a clean interrupt request for a processor's interrupt logic. The pin is first brought into the clock domain by a synchronizer. A byte-wide control register then picks one of two ways to read it. In level mode, a low pin asserts the request for as long as it stays low. In edge mode, each falling edge is captured into a pending latch. The latch holds until the interrupt is serviced, which is signalled by a one-cycle acknowledge, or until reset.

The control register has two live bits. The select bit picks edge or level mode. The enable bit connects the pin to the request logic or disconnects it. In normal operation the select bit locks after the first register write, so a configuration cannot later be overturned by accident. A special-mode input lifts that lock. The enable bit stays writable at all times. Clearing it masks the request but does not clear a captured edge.

Top module: `irq_pin_cond`

## Requirements
- R1: After reset, the control register reads 8'h40: select bit (bit 7) is 0, meaning level mode, and enable bit (bit 6) is 1. The request is 0 while the pin is high.
- R2: Register bits 5 down to 0 always read as zero, whatever value was written to them.
- R3: In level mode with the enable bit set, `irq_req` is high exactly while the synchronized pin is low. A pin change reaches `irq_req` after the second rising clock edge.
- R4: In edge mode, a synchronized 1-to-0 transition of the pin sets the pending latch. `irq_req` rises after the third clock edge following the pin fall and stays high after the pin returns high.
- R5: A one-cycle `irq_ack` clears the pending latch, so `irq_req` drops after that edge. In level mode, `irq_ack` has no effect on `irq_req`.
- R6: If a new falling edge is detected in the same cycle as `irq_ack`, the pending latch stays set.
- R7: With `special_mode` = 0, the first register write after reset sets a lock. Later writes cannot change bit 7.
- R8: With `special_mode` = 1, bit 7 is written by every write, and such writes do not set the lock.
- R9: Bit 6 is written by every write, regardless of the lock. While it is 0, `irq_req` is 0.
- R10: Clearing the enable bit does not clear a pending edge. Setting the enable bit again brings the request back without a new edge.
- R11: A pin held low in edge mode causes only one capture. Once acknowledged, it raises no further request until it goes high and falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| special_mode | input | 1 | 1 = special mode: select bit freely writable |
| pin_n | input | 1 | Asynchronous active-low interrupt pin |
| irq_ack | input | 1 | One-cycle pulse: interrupt serviced |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| irq_req | output | 1 | Interrupt request to the interrupt logic |

## Verification
Two functions can fall in the same cycle: the acknowledge that clears the pending latch, and the detection of a fresh falling edge that sets it. The bench provokes this by first leaving an edge pending. It then drops the pin again and raises `irq_ack` in exactly the cycle in which the synchronized fall is seen. The request must survive that cycle, and a later lone acknowledge must clear it. A second collision is a write arriving while the lock is already set. There the bench checks that bit 6 changes and bit 7 does not.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;

    localparam int REG_W       = 8;
    localparam int SEL_BIT     = 7;
    localparam int EN_BIT      = 6;
    localparam int SYNC_STAGES = 2;

    typedef enum logic {
        MODE_NORMAL  = 1'b0,
        MODE_SPECIAL = 1'b1
    } op_mode_e;

    typedef struct packed {
        logic edge_sel;
        logic pin_en;
    } ctrl_t;

    typedef struct packed {
        logic level_low;
        logic fall;
    } pin_evt_t;

    localparam ctrl_t CTRL_RESET = '{edge_sel: 1'b0, pin_en: 1'b1};

    function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_t c);
        logic [REG_W-1:0] r;
        r          = '0;
        r[SEL_BIT] = c.edge_sel;
        r[EN_BIT]  = c.pin_en;
        return r;
    endfunction

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= RESET_VAL;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RESET_VAL}};
                else     chain <= {chain[LAST-1:0], d};
            end
        end
    endgenerate

    assign q = chain[LAST];
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
    import irq_cond_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  op_mode_e         mode,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output ctrl_t            ctrl,
    output logic             locked,
    output logic [REG_W-1:0] rdata
);
    logic sel_writable;

    assign sel_writable = (mode == MODE_SPECIAL) || !locked;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= CTRL_RESET;
            locked <= 1'b0;
        end else if (wr) begin
            ctrl.pin_en <= wdata[EN_BIT];
            if (sel_writable) ctrl.edge_sel <= wdata[SEL_BIT];
            if (mode == MODE_NORMAL) locked <= 1'b1;
        end
    end

    assign rdata = pack_ctrl(ctrl);
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch
    import irq_cond_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sync_pin,
    input  logic     arm,
    input  logic     ack,
    output pin_evt_t evt,
    output logic     pending
);
    logic prev_pin;

    always_ff @(posedge clk) begin
        if (rst) prev_pin <= 1'b1;
        else     prev_pin <= sync_pin;
    end

    assign evt.fall      = prev_pin & ~sync_pin;
    assign evt.level_low = ~sync_pin;

    always_ff @(posedge clk) begin
        if (rst)                   pending <= 1'b0;
        else if (arm && evt.fall)  pending <= 1'b1;
        else if (ack)              pending <= 1'b0;
    end
endmodule

// File: rtl/irq_pin_cond.sv
module irq_pin_cond
    import irq_cond_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             special_mode,
    input  logic             pin_n,
    input  logic             irq_ack,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq_req
);
    op_mode_e mode;
    ctrl_t    ctrl;
    logic     sel_locked;
    logic     sync_pin;
    pin_evt_t evt;
    logic     pending;
    logic     source;

    assign mode = special_mode ? MODE_SPECIAL : MODE_NORMAL;

    irq_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_n),
        .q   (sync_pin)
    );

    irq_ctrl_reg u_reg (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .wr     (reg_wr),
        .wdata  (reg_wdata),
        .ctrl   (ctrl),
        .locked (sel_locked),
        .rdata  (reg_rdata)
    );

    irq_edge_latch u_edge (
        .clk      (clk),
        .rst      (rst),
        .sync_pin (sync_pin),
        .arm      (ctrl.edge_sel),
        .ack      (irq_ack),
        .evt      (evt),
        .pending  (pending)
    );

    assign source  = ctrl.edge_sel ? pending : evt.level_low;
    assign irq_req = ctrl.pin_en & source;
endmodule

// File: rtl/irq_pin_cond_chk.sv
module irq_pin_cond_chk (
    input logic       clk,
    input logic       rst,
    input logic       special_mode,
    input logic       irq_ack,
    input logic       reg_wr,
    input logic [7:0] reg_rdata,
    input logic       irq_req,
    input logic       sel_locked,
    input logic       sync_pin,
    input logic       fall,
    input logic       pending
);
    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[5:0] == 6'b0); // R2

    AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (!reg_rdata[7] && reg_rdata[6]) |-> (irq_req == !sync_pin)); // R3

    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (pending && !irq_ack) |=> pending); // R4

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !(reg_rdata[7] && fall)) |=> !pending); // R5

    AST_COINCIDENT_KEEP: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[7] && fall) |=> pending); // R6

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (sel_locked && !special_mode && reg_wr) |=> $stable(reg_rdata[7])); // R7

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !reg_rdata[6] |-> !irq_req); // R9
endmodule

bind irq_pin_cond irq_pin_cond_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .special_mode (special_mode),
    .irq_ack      (irq_ack),
    .reg_wr       (reg_wr),
    .reg_rdata    (reg_rdata),
    .irq_req      (irq_req),
    .sel_locked   (sel_locked),
    .sync_pin     (sync_pin),
    .fall         (evt.fall),
    .pending      (pending)
);

// File: tb/sim_irq_pin_cond.sv
`timescale 1ns/1ps
module sim_irq_pin_cond;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       special_mode = 1'b0;
    logic       pin_n = 1'b1;
    logic       irq_ack = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_req;

    int total = 0;
    int bad = 0;
    string phase = "R1";
    bit done = 0;

    always #2 clk = ~clk;

    irq_pin_cond u0 (
        .clk(clk), .rst(rst), .special_mode(special_mode), .pin_n(pin_n),
        .irq_ack(irq_ack), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req)
    );

    // behavioural reference model
    bit m_sel, m_en, m_lock, m_pend;
    bit hist[$] = '{1'b1, 1'b1, 1'b1};   // [0]=newest sample
    bit fall_now;

    always @(posedge clk) begin
        if (rst) begin
            m_sel = 0; m_en = 1; m_lock = 0; m_pend = 0;
            hist = '{1'b1, 1'b1, 1'b1};
        end else begin
            fall_now = hist[2] && !hist[1];
            if (m_sel && fall_now) m_pend = 1;
            else if (irq_ack)      m_pend = 0;
            if (reg_wr) begin
                m_en = reg_wdata[6];
                if (special_mode || !m_lock) m_sel = reg_wdata[7];
                if (!special_mode) m_lock = 1;
            end
            hist.push_front(pin_n);
            void'(hist.pop_back());
        end
    end

    function automatic bit exp_req();
        return m_en && (m_sel ? m_pend : !hist[1]);
    endfunction

    always @(negedge clk) begin
        if (!rst && !done) begin
            total++;
            if (irq_req !== exp_req() || reg_rdata !== {m_sel, m_en, 6'b0}) begin
                bad++;
                $display("FAIL %s model: req=%0b rdata=%h expected req=%0b rdata=%h",
                         phase, irq_req, reg_rdata, exp_req(), {m_sel, m_en, 6'b0});
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        reg_wr = 1; reg_wdata = v;
        tick(1);
        reg_wr = 0;
    endtask

    task automatic ack1();
        irq_ack = 1; tick(1); irq_ack = 0;
    endtask

    task automatic do_reset();
        rst = 1; tick(3); rst = 0;
    endtask

    initial begin
        tick(1);
        do_reset();
        phase = "R1";
        chk("R1", reg_rdata, 8'h40);
        chk("R1", {7'b0, irq_req}, 8'h00);

        phase = "R3";
        pin_n = 0; tick(1);
        chk("R3", {7'b0, irq_req}, 8'h00);
        tick(1);
        chk("R3", {7'b0, irq_req}, 8'h01);
        phase = "R5";
        ack1();
        chk("R5", {7'b0, irq_req}, 8'h01);   // ack ignored in level mode
        phase = "R3";
        pin_n = 1; tick(2);
        chk("R3", {7'b0, irq_req}, 8'h00);

        phase = "R9";
        wr(8'h00);
        pin_n = 0; tick(3);
        chk("R9", {7'b0, irq_req}, 8'h00);
        wr(8'h40);
        chk("R9", {7'b0, irq_req}, 8'h01);

        phase = "R7";
        wr(8'hC0);
        chk("R7", reg_rdata, 8'h40);
        phase = "R2";
        wr(8'h7F);
        chk("R2", reg_rdata, 8'h40);
        wr(8'h40);

        phase = "R8";
        special_mode = 1;
        wr(8'hC0);
        chk("R8", reg_rdata, 8'hC0);
        tick(3);
        phase = "R4";
        chk("R4", {7'b0, irq_req}, 8'h00);   // held low, no edge seen in edge mode

        pin_n = 1; tick(3);
        pin_n = 0; tick(2);
        chk("R4", {7'b0, irq_req}, 8'h00);
        tick(1);
        chk("R4", {7'b0, irq_req}, 8'h01);
        pin_n = 1; tick(4);
        chk("R4", {7'b0, irq_req}, 8'h01);

        phase = "R5";
        ack1();
        chk("R5", {7'b0, irq_req}, 8'h00);

        phase = "R6";
        pin_n = 0; tick(3); pin_n = 1; tick(3);   // leave an edge pending
        chk("R6", {7'b0, irq_req}, 8'h01);
        pin_n = 0; tick(2);
        irq_ack = 1; tick(1); irq_ack = 0;        // ack in the cycle the fall is seen
        chk("R6", {7'b0, irq_req}, 8'h01);
        ack1();
        chk("R6", {7'b0, irq_req}, 8'h00);

        phase = "R11";
        tick(5);                                   // pin still held low
        chk("R11", {7'b0, irq_req}, 8'h00);

        phase = "R10";
        pin_n = 1; tick(3); pin_n = 0; tick(3);
        chk("R10", {7'b0, irq_req}, 8'h01);
        wr(8'h80);
        chk("R10", {7'b0, irq_req}, 8'h00);
        tick(3);
        wr(8'hC0);
        chk("R10", {7'b0, irq_req}, 8'h01);
        ack1();

        phase = "R8";
        do_reset();
        wr(8'h80);                                 // special write: no lock
        special_mode = 0;
        phase = "R7";
        wr(8'h40);
        chk("R7", reg_rdata, 8'h40);               // first normal write accepted
        wr(8'hC0);
        chk("R7", reg_rdata, 8'h40);
        wr(8'h00);
        chk("R9", reg_rdata, 8'h00);

        tick(2);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule